// File: doc/BRIEF.md
# Indexed Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) that gives a host access to a small file of eight-bit configuration registers for a clock-generation device. The host addresses the target, sends one byte that selects a register index, and then either writes a run of bytes or issues a repeated START and reads a run of bytes. The index steps forward by one after every byte that is transferred. A strap pin selects one of two bus addresses, so two of these devices can share one bus.

The register file has twelve entries. Eight of them can be written and read back. One can be written but reads back as zero. Three are read-only and show the live values of external status inputs. Every writable register is visible in parallel on a configuration output bus.

SCL and SDA are sampled by the system clock, passed through a synchronizer and a glitch filter, and only then decoded into START, STOP and bit edges. The target pulls SDA low through an output enable and never drives it high.

Top module: `cfg_i2c_target`

## Requirements
- R1: With `addr_sel_i` low the target answers the 7-bit address 0x26 (8-bit write 0x4C, read 0x4D). With it high the target answers 0x27 (write 0x4E, read 0x4F). Any other address gets no ACK, and SDA is left released.
- R2: After a write address, the first data byte loads the register index. Each later byte is written to the indexed register, is ACKed, and then increments the index.
- R3: A read returns the register at the current index, MSB first, and increments the index after each byte. The index survives a STOP and a repeated START, so a write of the index followed by a repeated-START read returns the selected register.
- R4: Indices 0 to 7 are read/write, index 8 is write-only, and indices 9 to 11 are read-only. Register k (k = 0..8) appears on `cfg_o[8k+7:8k]`. `status_i[8j+7:8j]` is read at index 9+j.
- R5: A read of index 8 returns 0x00, whatever was written there.
- R6: A write to indices 9 to 11 is ACKed but changes no register and no output.
- R7: A data byte written at an index of 12 or above gets no ACK and changes nothing. A read at such an index returns 0xFF.
- R8: After the host NACKs a read byte, the target releases SDA and stays released until the next START or STOP.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_W` system clocks (default 3) is ignored.
- R10: Transfers complete correctly with SCL phases of both 100 kHz and 400 kHz bus rates, measured against the system clock.
- R11: Synchronous reset clears all writable registers to 0x00 and releases SDA.
- R12: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel_i | input | 1 | Strap that selects the bus address pair |
| scl_i | input | 1 | Bus clock line, as seen on the pin |
| sda_i | input | 1 | Bus data line, as seen on the pin |
| sda_o | output | 1 | Data value driven onto the bus, always 0 (open drain) |
| sda_oe_o | output | 1 | High to pull SDA low |
| cfg_o | output | 72 | Writable registers 0 to 8, one byte each |
| status_i | input | 24 | Status bytes read at indices 9 to 11 |

## Verification
The hardest state to reach is a burst that runs past a boundary of the map without a STOP. Examples are a read whose index walks through the write-only entry, or a write stream whose index passes the last register, where the ACK/NACK decision depends on an index that the target computed itself. The bench reaches these states through its vector table, where each entry writes a chosen index and then reads it back with a repeated START, and through directed multi-byte bursts. The stored index is also driven across a STOP by a transaction that only loads the index. A further pass injects single-cycle pulses on both lines during every high SCL phase, to show that the filter keeps the bit count intact.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK, S_WAIT
  } bus_st_e;
endpackage

// File: rtl/i2c_glitch_filt.sv
module i2c_glitch_filt #(
  parameter int SYNC_W = 2,
  parameter int FILT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_W-1:0] sync_q;
  logic [FILT_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], din};
      hist_q <= {hist_q[FILT_W-2:0], sync_q[SYNC_W-1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int DW   = 8,
  parameter int N_RW = 8,
  parameter int N_WO = 1,
  parameter int N_RO = 3,
  parameter int IW   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  input  logic [N_RO*DW-1:0]       ro_i,
  output logic [(N_RW+N_WO)*DW-1:0] cfg_o,
  output logic [DW-1:0]            rdata
);
  localparam int N_W = N_RW + N_WO;
  localparam int AW  = (N_W > 1) ? $clog2(N_W) : 1;

  logic [DW-1:0] regs_q [N_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_W; k++) regs_q[k] <= '0;
    end else if (we && idx < IW'(N_W)) begin
      regs_q[idx[AW-1:0]] <= wdata;
    end
  end

  for (genvar g = 0; g < N_W; g++) begin : g_out
    assign cfg_o[g*DW +: DW] = regs_q[g];
  end

  always_comb begin
    rdata = '1;
    for (int k = 0; k < N_RW; k++)
      if (idx == IW'(k)) rdata = regs_q[k];
    for (int k = N_RW; k < N_W; k++)
      if (idx == IW'(k)) rdata = '0;
    for (int k = 0; k < N_RO; k++)
      if (idx == IW'(N_W + k)) rdata = ro_i[k*DW +: DW];
  end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int         N_RW      = 8,
  parameter int         N_WO      = 1,
  parameter int         N_RO      = 3,
  parameter int         SYNC_W    = 2,
  parameter int         FILT_W    = 3,
  parameter logic [6:0] BASE_ADDR = 7'h26
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      addr_sel_i,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_o,
  output logic                      sda_oe_o,
  output logic [(N_RW+N_WO)*8-1:0]  cfg_o,
  input  logic [N_RO*8-1:0]         status_i
);
  localparam int N_REG = N_RW + N_WO + N_RO;

  logic [1:0] line_raw, line_f;
  assign line_raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filt #(.SYNC_W(SYNC_W), .FILT_W(FILT_W)) u_filt (
      .clk(clk), .rst(rst), .din(line_raw[g]), .dout(line_f[g]));
  end

  logic scl_f, sda_f, scl_d, sda_d;
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

  bus_st_e    st_q;
  logic [3:0] bcnt_q;
  logic [7:0] sr_q, tx_q, idx_q, rdata, idx_nx;
  logic       idx_pend_q, rw_q, mack_q, we;
  logic [6:0] my_addr;
  logic       idx_ok;

  assign my_addr = {BASE_ADDR[6:1], addr_sel_i};
  assign idx_ok  = idx_q < 8'(N_REG);
  assign idx_nx  = (idx_q == 8'hFF) ? idx_q : idx_q + 8'd1;
  assign we      = (st_q == S_WBYTE) && scl_fall && (bcnt_q == 4'd8)
                   && !idx_pend_q && idx_ok;
  assign sda_o   = 1'b0;

  cfg_regfile #(.DW(8), .N_RW(N_RW), .N_WO(N_WO), .N_RO(N_RO), .IW(8)) u_regs (
    .clk(clk), .rst(rst), .we(we), .idx(idx_q), .wdata(sr_q),
    .ro_i(status_i), .cfg_o(cfg_o), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;  sda_d <= 1'b1;
      st_q <= S_IDLE; bcnt_q <= '0; sr_q <= '0; tx_q <= '0;
      idx_q <= '0; idx_pend_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      if (start_det) begin
        st_q <= S_ADDR; bcnt_q <= '0; sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st_q <= S_IDLE; sda_oe_o <= 1'b0;
      end else begin
        if (scl_rise && (st_q == S_ADDR || st_q == S_WBYTE || st_q == S_RBYTE))
          bcnt_q <= bcnt_q + 4'd1;
        if (scl_rise && (st_q == S_ADDR || st_q == S_WBYTE))
          sr_q <= {sr_q[6:0], sda_f};
        if (scl_rise && st_q == S_RACK)
          mack_q <= ~sda_f;
        if (scl_fall) begin
          unique case (st_q)
            S_ADDR: if (bcnt_q == 4'd8) begin
              if (sr_q[7:1] == my_addr) begin
                rw_q <= sr_q[0]; sda_oe_o <= 1'b1; st_q <= S_AACK;
                if (!sr_q[0]) idx_pend_q <= 1'b1;
              end else st_q <= S_WAIT;
            end
            S_AACK: begin
              bcnt_q <= '0;
              if (rw_q) begin
                tx_q <= rdata; sda_oe_o <= ~rdata[7]; st_q <= S_RBYTE;
              end else begin
                sda_oe_o <= 1'b0; st_q <= S_WBYTE;
              end
            end
            S_WBYTE: if (bcnt_q == 4'd8) begin
              if (idx_pend_q) begin
                idx_q <= sr_q; idx_pend_q <= 1'b0;
                sda_oe_o <= 1'b1; st_q <= S_WACK;
              end else if (idx_ok) begin
                idx_q <= idx_nx; sda_oe_o <= 1'b1; st_q <= S_WACK;
              end else st_q <= S_WAIT;
            end
            S_WACK: begin
              sda_oe_o <= 1'b0; bcnt_q <= '0; st_q <= S_WBYTE;
            end
            S_RBYTE: if (bcnt_q == 4'd8) begin
              sda_oe_o <= 1'b0; idx_q <= idx_nx; st_q <= S_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0}; sda_oe_o <= ~tx_q[6];
            end
            S_RACK: begin
              bcnt_q <= '0;
              if (mack_q) begin
                tx_q <= rdata; sda_oe_o <= ~rdata[7]; st_q <= S_RBYTE;
              end else begin
                sda_oe_o <= 1'b0; st_q <= S_WAIT;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_target_sva.sv
module cfg_i2c_target_sva
  import cfg_i2c_pkg::*;
#(
  parameter int CW = 72
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic [CW-1:0] cfg_o,
  input bus_st_e       st_q
);
  // R11: one cycle after reset is applied, SDA is released and the registers are zero
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!sda_oe_o && cfg_o == '0));

  // R8: no drive while idle or while waiting after a NACK
  p_wait_release_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE || st_q == S_WAIT) |-> !sda_oe_o);

  // R12: the output enable moves only while the bus clock is low
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_i);

  // R2: register contents change only while the bus clock is low
  p_cfg_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> !scl_i);

  // R3: SDA is pulled only during an ACK slot or a read data byte
  p_drive_phase_r3: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> (st_q == S_AACK || st_q == S_WACK || st_q == S_RBYTE));
endmodule

bind cfg_i2c_target cfg_i2c_target_sva #(.CW((N_RW+N_WO)*8)) u_sva (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .cfg_o(cfg_o), .st_q(st_q));

// File: tb/cfg_i2c_target_tb.sv
module cfg_i2c_target_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, addr_sel, scl, sda_m, sda_o, sda_oe, sda_bus;
  logic [71:0] cfg;
  logic [23:0] status = {8'hC3, 8'hB2, 8'hA1};
  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_target u_dut (
    .clk(clk), .rst(rst), .addr_sel_i(addr_sel), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .cfg_o(cfg), .status_i(status));

  int checks = 0, errors = 0, H = 20;
  bit glitch = 0, done = 0;
  logic [7:0] dev_w = 8'h4C;

  typedef struct packed {
    logic [7:0] idx; logic [7:0] wd; logic wack; logic [7:0] rd;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{8'd0,   8'h5A, 1'b1, 8'h5A},
    '{8'd7,   8'hC3, 1'b1, 8'hC3},
    '{8'd8,   8'h77, 1'b1, 8'h00},
    '{8'd9,   8'h12, 1'b1, 8'hA1},
    '{8'd11,  8'hFF, 1'b1, 8'hC3},
    '{8'd12,  8'h33, 1'b0, 8'hFF},
    '{8'hFF,  8'h10, 1'b0, 8'hFF}};

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic rd);
    wt(H/2); sda_m = b; wt(H/2); scl = 1'b1; wt(H/2);
    rd = sda_bus;
    if (glitch) begin
      scl = 1'b0; wt(1); scl = 1'b1;
      if (b) begin sda_m = 1'b0; wt(1); sda_m = 1'b1; end
    end
    wt(H/2); scl = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(d[i], r);
    bitx(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, r); d[i] = r; end
    bitx(~mack, r);
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, output logic wack);
    logic a;
    start_c(); wr_byte(dev_w, a); wr_byte(idx, a); wr_byte(d, wack); stop_c();
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    start_c(); wr_byte(dev_w, a); wr_byte(idx, a);
    start_c(); wr_byte(dev_w | 8'h01, a); rd_byte(1'b0, d); stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] d;
    rst = 1'b1; addr_sel = 1'b0; scl = 1'b1; sda_m = 1'b1;
    wt(5); rst = 1'b0; wt(5);
    chk("R11 cfg after reset", cfg, 72'h0);
    chk("R11 sda released", {71'h0, sda_oe}, 72'h0);

    foreach (VEC[n]) begin
      reg_write(VEC[n].idx, VEC[n].wd, a);
      chk("R2/R6/R7 data ack", {71'h0, a}, {71'h0, VEC[n].wack});
      reg_read(VEC[n].idx, d);
      chk("R3/R5/R6/R7 readback", {64'h0, d}, {64'h0, VEC[n].rd});
    end
    chk("R4 R6 R7 cfg map", cfg, {8'h77, 8'hC3, 48'h0, 8'h5A});

    // R2 burst write with auto increment
    start_c(); wr_byte(dev_w, a); wr_byte(8'd2, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a); stop_c();
    chk("R2 burst write", {48'h0, cfg[39:16]}, {48'h0, 24'h332211});

    // R3 burst read with repeated start, R8 release after NACK
    start_c(); wr_byte(dev_w, a); wr_byte(8'd2, a);
    start_c(); wr_byte(dev_w | 8'h01, a);
    begin
      logic [7:0] b0, b1, b2;
      rd_byte(1'b1, b0); rd_byte(1'b1, b1); rd_byte(1'b0, b2);
      chk("R3 burst read", {48'h0, b0, b1, b2}, {48'h0, 24'h112233});
    end
    wt(H); chk("R8 released after NACK", {71'h0, sda_oe}, 72'h0);
    wt(H); chk("R8 still released", {71'h0, sda_oe}, 72'h0);
    stop_c();

    // R3 index survives STOP
    start_c(); wr_byte(dev_w, a); wr_byte(8'd3, a); stop_c();
    start_c(); wr_byte(dev_w | 8'h01, a); rd_byte(1'b0, d); stop_c();
    chk("R3 index kept across STOP", {64'h0, d}, {64'h0, 8'h22});

    // R5 read burst walks across the write-only entry
    start_c(); wr_byte(dev_w, a); wr_byte(8'd7, a);
    start_c(); wr_byte(dev_w | 8'h01, a);
    begin
      logic [7:0] b0, b1, b2;
      rd_byte(1'b1, b0); rd_byte(1'b1, b1); rd_byte(1'b0, b2);
      chk("R5 burst across map", {48'h0, b0, b1, b2}, {48'h0, 24'hC300A1});
    end
    stop_c();

    // R1 address decode and strap
    start_c(); wr_byte(8'h4E, a); stop_c();
    chk("R1 wrong address NACK (strap low)", {71'h0, a}, 72'h0);
    addr_sel = 1'b1; wt(4);
    start_c(); wr_byte(8'h4C, a); stop_c();
    chk("R1 old address NACK (strap high)", {71'h0, a}, 72'h0);
    dev_w = 8'h4E;
    reg_write(8'd5, 8'h3C, a);
    chk("R1 strap high write ACK", {71'h0, a}, {71'h0, 1'b1});
    reg_read(8'd5, d);
    chk("R1 strap high read", {64'h0, d}, {64'h0, 8'h3C});

    // R9 glitches on SCL and SDA
    glitch = 1;
    reg_write(8'd1, 8'h96, a);
    glitch = 0;
    reg_read(8'd1, d);
    chk("R9 glitch filtered", {64'h0, d}, {64'h0, 8'h96});

    // R10 slow and fast bus rates (200 MHz system clock)
    H = 1000;
    reg_write(8'd6, 8'hE1, a);
    chk("R10 100 kHz write ACK", {71'h0, a}, {71'h0, 1'b1});
    H = 250;
    reg_read(8'd6, d);
    chk("R10 400 kHz read", {64'h0, d}, {64'h0, 8'hE1});
    H = 20;

    // R11 reset clears registers again
    wt(4); rst = 1'b1; wt(2); rst = 1'b0; wt(2);
    chk("R11 cfg after second reset", cfg, 72'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule